// File: doc/BRIEF.md
# Address Map Classifier with Abort Flags

This block sorts every address a processor core puts out into one region of a 32-bit system map. It also reports whether the access must abort. The map holds these regions:

- A code store at the bottom of the space, whose size is a parameter.
- A static RAM at 0x4000_0000, whose size is also a parameter.
- An optional 8 kB DMA buffer RAM.
- A 12 kB boot block just below 2 GB.
- Two 2 MB peripheral spaces, each cut into 128 slots of 16 kB. The low-speed space starts at 0xE000_0000 and the high-speed space fills the top of the map.

Everything else is reserved.

Each request carries a valid strobe, an address and a flag that marks it as an instruction fetch or a data access. One clock later the block returns the region code, the 7-bit slot index and two abort flags. The prefetch-abort flag covers fetches. The data-abort flag covers loads and stores.

Whether an access aborts depends on its type. A fetch from any peripheral address always aborts. A data access aborts only when its slot is unassigned. An undefined offset inside an assigned slot passes without an abort, so it aliases onto some register of that peripheral. Which low-speed slots are populated is set by a constant 128-bit mask.

Top module: `addr_map_decoder`

## Requirements
- R1: The response appears exactly one clock after the request. `rspValid` is high in the cycle after `reqValid` was sampled high. In the cycle after `reqValid` was low, every output is 0. During reset every output is 0.
- R2: Addresses below FLASH_KB*1024 give region code 1 (code store). The rest of the space up to 0x3FFF_FFFF is reserved (region code 0).
- R3: Addresses from 0x4000_0000 to 0x4000_0000+SRAM_KB*1024-1 give region code 2. The space from the end of the RAM up to 0x7FFF_CFFF is reserved, apart from the window in R4.
- R4: With HAS_DMA_RAM set, 0x7FD0_0000 to 0x7FD0_1FFF gives region code 4. With it clear, that window is reserved.
- R5: Addresses 0x7FFF_D000 to 0x7FFF_FFFF give region code 3 (boot block).
- R6: 0xE000_0000 to 0xE01F_FFFF gives region code 6 (low-speed peripherals). 0xFFE0_0000 to 0xFFFF_FFFF gives region code 5 (high-speed peripherals). For both, `rspSlot` equals address bits [20:14]. For every other region `rspSlot` is 0.
- R7: 0x8000_0000 to 0xDFFF_FFFF and 0xE020_0000 to 0xFFDF_FFFF are reserved: region code 0 and slot 0.
- R8: An access to a reserved address aborts. A fetch raises only `rspPrefetchAbort`. A data access raises only `rspDataAbort`.
- R9: A fetch from either peripheral space raises `rspPrefetchAbort`, even when the slot is assigned.
- R10: A data access to a low-speed slot whose bit in LS_SLOT_MASK is 0 raises `rspDataAbort`. A data access at any offset inside a slot whose bit is 1 raises no abort. The default mask assigns slots 0–5, 7–11, 13, 23, 24, 26, 27, 36 and 127.
- R11: In the high-speed space only 0xFFFF_F000 to 0xFFFF_FFFF is assigned. A data access anywhere else in that space raises `rspDataAbort`.
- R12: The two abort flags are never high together. An access to the code store, RAM, DMA RAM or boot block never aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Byte address to classify |
| reqFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspRegion | output | 3 | Region code: 0 reserved, 1 code store, 2 RAM, 3 boot, 4 DMA RAM, 5 high-speed peripheral, 6 low-speed peripheral |
| rspSlot | output | 7 | Peripheral slot index, 0 outside the peripheral spaces |
| rspPrefetchAbort | output | 1 | Fetch must abort |
| rspDataAbort | output | 1 | Data access must abort |

## Verification
Some rules hold on every cycle, and the assertions check these:
- The two abort flags never rise together, and no flag is high without a response.
- The response follows the strobe by exactly one cycle.
- A fetch into peripheral space always raises the prefetch abort.
- An unassigned slot always raises the data abort.
- A reserved response always carries exactly one abort flag.

The exact region limits are another matter. These include the off-by-one edges at the end of the code store and the RAM, the carved DMA window, the boot-block start and the edges of both peripheral spaces, as well as the exact set of populated slots and the silent aliasing inside an assigned slot. Only the bench's directed and random address streams, compared against an independent map model, can show these.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

  localparam int SLOT_W      = 7;
  localparam int SLOT_COUNT  = 1 << SLOT_W;
  localparam int SLOT_OFS_W  = 14;

  typedef enum logic [2:0] {
    RGN_NONE  = 3'd0,
    RGN_FLASH = 3'd1,
    RGN_SRAM  = 3'd2,
    RGN_BOOT  = 3'd3,
    RGN_DMA   = 3'd4,
    RGN_HSP   = 3'd5,
    RGN_LSP   = 3'd6
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } dp_strobe_t;

  // classification handed back from datapath to control
  typedef struct packed {
    logic isReserved;
    logic isPeriph;
    logic slotAssigned;
  } addr_class_t;

  localparam logic [31:0] SRAM_BASE     = 32'h4000_0000;
  localparam logic [31:0] DMA_BASE      = 32'h7FD0_0000;
  localparam logic [31:0] DMA_LAST      = 32'h7FD0_1FFF;
  localparam logic [31:0] BOOT_BASE     = 32'h7FFF_D000;
  localparam logic [10:0] LS_SPACE_TAG  = 11'h700;
  localparam logic [10:0] HS_SPACE_TAG  = 11'h7FF;
  localparam logic [SLOT_W-1:0] HS_IRQ_SLOT = 7'd127;

endpackage

// File: rtl/addr_map_datapath.sv
module addr_map_datapath
  import addr_map_pkg::*;
#(
  parameter int FLASH_KB = 512,
  parameter int SRAM_KB  = 32,
  parameter bit HAS_DMA_RAM = 1'b1,
  parameter logic [SLOT_COUNT-1:0] LS_SLOT_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       addr,
  input  dp_strobe_t        strobe,
  output addr_class_t       cls,
  output region_e           regionQ,
  output logic [SLOT_W-1:0] slotQ
);

  localparam logic [32:0] FLASH_END = 33'(FLASH_KB) << 10;
  localparam logic [32:0] SRAM_END  = {1'b0, SRAM_BASE} + (33'(SRAM_KB) << 10);

  logic inFlash, inSram, inDma, inBoot, inLs, inHs;
  logic [SLOT_W-1:0] slotIdx;
  region_e           rgnD;
  logic [SLOT_W-1:0] slotD;
  logic              periphD, assignedD;

  assign inFlash = {1'b0, addr} < FLASH_END;
  assign inSram  = (addr >= SRAM_BASE) && ({1'b0, addr} < SRAM_END);
  assign inBoot  = (addr >= BOOT_BASE) && !addr[31];
  assign inLs    = addr[31:21] == LS_SPACE_TAG;
  assign inHs    = addr[31:21] == HS_SPACE_TAG;
  assign slotIdx = addr[SLOT_OFS_W+SLOT_W-1:SLOT_OFS_W];

  generate
    if (HAS_DMA_RAM) begin : g_dma
      assign inDma = (addr >= DMA_BASE) && (addr <= DMA_LAST);
    end else begin : g_no_dma
      assign inDma = 1'b0;
    end
  endgenerate

  always_comb begin
    rgnD      = RGN_NONE;
    slotD     = '0;
    periphD   = 1'b0;
    assignedD = 1'b0;
    if (inFlash) begin
      rgnD = RGN_FLASH;
    end else if (inSram) begin
      rgnD = RGN_SRAM;
    end else if (inDma) begin
      rgnD = RGN_DMA;
    end else if (inBoot) begin
      rgnD = RGN_BOOT;
    end else if (inLs) begin
      rgnD      = RGN_LSP;
      slotD     = slotIdx;
      periphD   = 1'b1;
      assignedD = LS_SLOT_MASK[slotIdx];
    end else if (inHs) begin
      rgnD      = RGN_HSP;
      slotD     = slotIdx;
      periphD   = 1'b1;
      assignedD = (slotIdx == HS_IRQ_SLOT) && (addr[13:12] == 2'b11);
    end
  end

  assign cls.isReserved   = (rgnD == RGN_NONE);
  assign cls.isPeriph     = periphD;
  assign cls.slotAssigned = assignedD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionQ <= RGN_NONE;
      slotQ   <= '0;
    end else if (strobe.capture) begin
      regionQ <= rgnD;
      slotQ   <= slotD;
    end else if (strobe.clear) begin
      regionQ <= RGN_NONE;
      slotQ   <= '0;
    end
  end

  // R6
  slot_zero_outside_periph_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regionQ != RGN_LSP && regionQ != RGN_HSP) |-> slotQ == '0);

  // R7
  reserved_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && addr[31:30] == 2'b10 && addr[31:29] != 3'b111) |=> regionQ == RGN_NONE);

endmodule

// File: rtl/addr_map_ctrl.sv
module addr_map_ctrl
  import addr_map_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqFetch,
  input  addr_class_t cls,
  output dp_strobe_t  strobe,
  output logic        rspValid,
  output logic        pAbort,
  output logic        dAbort
);

  logic fetchAbortD, dataAbortD;

  assign strobe.capture = reqValid;
  assign strobe.clear   = !reqValid;

  assign fetchAbortD = reqValid &&  reqFetch && (cls.isReserved || cls.isPeriph);
  assign dataAbortD  = reqValid && !reqFetch &&
                       (cls.isReserved || (cls.isPeriph && !cls.slotAssigned));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      pAbort   <= 1'b0;
      dAbort   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      pAbort   <= fetchAbortD;
      dAbort   <= dataAbortD;
    end
  end

  // R12
  no_dual_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pAbort && dAbort));

  // R1
  abort_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pAbort || dAbort) |-> rspValid);

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R9
  periph_fetch_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFetch && cls.isPeriph) |=> (pAbort && !dAbort));

  // R10
  unassigned_data_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFetch && cls.isPeriph && !cls.slotAssigned) |=> dAbort);

endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
  import addr_map_pkg::*;
#(
  parameter int FLASH_KB = 512,
  parameter int SRAM_KB  = 32,
  parameter bit HAS_DMA_RAM = 1'b1,
  parameter logic [127:0] LS_SLOT_MASK =
    128'h8000_0000_0000_0000_0000_0010_0D80_2FBF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqFetch,
  output logic        rspValid,
  output logic [2:0]  rspRegion,
  output logic [6:0]  rspSlot,
  output logic        rspPrefetchAbort,
  output logic        rspDataAbort
);

  dp_strobe_t  strobe;
  addr_class_t cls;
  region_e     regionQ;

  addr_map_datapath #(
    .FLASH_KB(FLASH_KB),
    .SRAM_KB(SRAM_KB),
    .HAS_DMA_RAM(HAS_DMA_RAM),
    .LS_SLOT_MASK(LS_SLOT_MASK)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .addr(reqAddr),
    .strobe(strobe),
    .cls(cls),
    .regionQ(regionQ),
    .slotQ(rspSlot)
  );

  addr_map_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqFetch(reqFetch),
    .cls(cls),
    .strobe(strobe),
    .rspValid(rspValid),
    .pAbort(rspPrefetchAbort),
    .dAbort(rspDataAbort)
  );

  assign rspRegion = regionQ;

  // R8
  reserved_single_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && regionQ == RGN_NONE) |-> (rspPrefetchAbort != rspDataAbort));

  // R12
  memory_no_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regionQ inside {RGN_FLASH, RGN_SRAM, RGN_BOOT, RGN_DMA}) |->
      (!rspPrefetchAbort && !rspDataAbort));

endmodule

// File: tb/sim_addr_map_decoder.sv
module sim_addr_map_decoder;

  localparam int FLASH_KB = 512;
  localparam int SRAM_KB  = 32;

  typedef struct {
    bit    v;
    int    rgn;
    int    slot;
    bit    pab;
    bit    dab;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqFetch = 1'b0;
  logic        rspValid;
  logic [2:0]  rspRegion;
  logic [6:0]  rspSlot;
  logic        rspPrefetchAbort;
  logic        rspDataAbort;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t expQ[$];
  int lsAssigned[$] = '{0, 1, 2, 3, 4, 5, 7, 8, 9, 10, 11, 13, 23, 24, 26, 27, 36, 127};

  always #5 clk = ~clk;

  addr_map_decoder #(.FLASH_KB(FLASH_KB), .SRAM_KB(SRAM_KB), .HAS_DMA_RAM(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqFetch(reqFetch),
    .rspValid(rspValid), .rspRegion(rspRegion), .rspSlot(rspSlot),
    .rspPrefetchAbort(rspPrefetchAbort), .rspDataAbort(rspDataAbort));

  function automatic bit lsIsAssigned(int s);
    foreach (lsAssigned[i]) if (lsAssigned[i] == s) return 1'b1;
    return 1'b0;
  endfunction

  function automatic exp_t refModel(bit v, logic [31:0] a, bit f);
    exp_t e;
    longint ua;
    bit resv;
    e = '{v: v, rgn: 0, slot: 0, pab: 0, dab: 0, tag: "R1"};
    if (!v) return e;
    ua = longint'(a);
    resv = 1'b0;
    if (ua < longint'(FLASH_KB) * 1024) begin e.rgn = 1; e.tag = "R2"; end
    else if (ua < 64'h4000_0000) begin resv = 1'b1; e.tag = "R2"; end
    else if (ua < 64'h4000_0000 + longint'(SRAM_KB) * 1024) begin e.rgn = 2; e.tag = "R3"; end
    else if (ua >= 64'h7FD0_0000 && ua <= 64'h7FD0_1FFF) begin e.rgn = 4; e.tag = "R4"; end
    else if (ua < 64'h7FFF_D000) begin resv = 1'b1; e.tag = "R3"; end
    else if (ua < 64'h8000_0000) begin e.rgn = 3; e.tag = "R5"; end
    else if (ua < 64'hE000_0000) begin resv = 1'b1; e.tag = "R7"; end
    else if (ua < 64'hE020_0000) begin
      e.rgn = 6; e.slot = int'((ua - 64'hE000_0000) / 16384);
      if (f) begin e.pab = 1; e.tag = "R9"; end
      else begin e.dab = !lsIsAssigned(e.slot); e.tag = "R10"; end
    end
    else if (ua < 64'hFFE0_0000) begin resv = 1'b1; e.tag = "R7"; end
    else begin
      e.rgn = 5; e.slot = int'((ua - 64'hFFE0_0000) / 16384);
      if (f) begin e.pab = 1; e.tag = "R9"; end
      else begin e.dab = (ua < 64'hFFFF_F000); e.tag = "R11"; end
    end
    if (resv) begin
      if (f) e.pab = 1; else e.dab = 1;
      e.tag = {e.tag, "/R8"};
    end
    return e;
  endfunction

  task automatic compareNow();
    exp_t e;
    e = expQ.pop_front();
    checks++;
    if (rspValid !== e.v || int'(rspRegion) != e.rgn || int'(rspSlot) != e.slot ||
        rspPrefetchAbort !== e.pab || rspDataAbort !== e.dab) begin
      errors++;
      $display("FAIL %s: got v=%0d rgn=%0d slot=%0d pab=%0d dab=%0d, expected v=%0d rgn=%0d slot=%0d pab=%0d dab=%0d",
               e.tag, rspValid, rspRegion, rspSlot, rspPrefetchAbort, rspDataAbort,
               e.v, e.rgn, e.slot, e.pab, e.dab);
    end
    checks++;
    if (rspPrefetchAbort && rspDataAbort) begin  // R12
      errors++;
      $display("FAIL R12: got pab=1 dab=1, expected at most one flag");
    end
  endtask

  task automatic step(bit v, logic [31:0] a, bit f);
    @(negedge clk);
    compareNow();
    reqValid = v;
    reqAddr  = a;
    reqFetch = f;
    expQ.push_back(refModel(v, a, f));
  endtask

  function automatic void summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected end of run");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] dirList[$];
    logic [31:0] bases[$];
    dirList = '{32'h0000_0000, 32'h0007_FFFC, 32'h0008_0000, 32'h3FFF_FFFC,
                32'h4000_0000, 32'h4000_7FFF, 32'h4000_8000, 32'h7FCF_FFFF,
                32'h7FD0_0000, 32'h7FD0_1FFF, 32'h7FD0_2000, 32'h7FFF_CFFF,
                32'h7FFF_D000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hDFFF_FFFF,
                32'hE000_0000, 32'hE000_D000, 32'hE001_8000, 32'hE01F_C140,
                32'hE01F_BFFF, 32'hE009_0ABC, 32'hE020_0000, 32'hFFDF_FFFF,
                32'hFFE0_0000, 32'hFFFF_EFFF, 32'hFFFF_F000, 32'hFFFF_FFFF};
    bases = '{32'h0000_0000, 32'h4000_0000, 32'h7FD0_0000, 32'h7FFF_C000,
              32'hE000_0000, 32'hFFE0_0000, 32'h8000_0000, 32'hE020_0000};

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (rspValid || rspRegion != 0 || rspSlot != 0 || rspPrefetchAbort || rspDataAbort) begin
        errors++;
        $display("FAIL R1: got v=%0d rgn=%0d slot=%0d pab=%0d dab=%0d during reset, expected all 0",
                 rspValid, rspRegion, rspSlot, rspPrefetchAbort, rspDataAbort);
      end
    end
    rstN = 1'b1;
    expQ.push_back(refModel(1'b0, '0, 1'b0));

    // directed corners, data then fetch, with idle gaps (R1)
    foreach (dirList[i]) begin
      step(1'b1, dirList[i], 1'b0);
      step(1'b1, dirList[i], 1'b1);
      if (i % 3 == 0) step(1'b0, dirList[i], 1'b1);
    end

    // every low-speed slot, data access at a mid-slot offset (R10)
    for (int s = 0; s < 128; s++) step(1'b1, 32'hE000_0000 + 32'(s) * 32'h4000 + 32'h1230, 1'b0);

    // random addresses biased towards region edges
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 8) a = bases[pick] + ($urandom & 32'h003F_FFFF);
      else a = $urandom;
      step($urandom_range(0, 7) != 0, a, $urandom_range(0, 1) == 1);
    end

    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule